// File: doc/BRIEF.md
# Floating-point minimum/maximum unit

This unit picks the smaller or the larger of two 64-bit binary floating-point operands. A 4-bit mode chooses the semantic family. The families differ in how they treat NaN inputs and signed zeros. Each family can compare either signed values or magnitudes. The result is registered, so it appears one clock edge after the operands are presented.

Min/max never rounds, so a single-precision value widened to double format gives the same answer through this one datapath. No separate single-precision path exists. A record input asks for a 4-bit comparison summary alongside the result. An invalid flag reports any signalling-NaN operand.

Top module: `fp_minmax_unit`

## Requirements
- R1: While rst_ni is low, and on the first edge after it rises with no operation applied, res_o, invalid_o and cond_o are all zero.
- R2: res_o, invalid_o and cond_o reflect the inputs sampled at the previous rising edge of clk_i. Mode bit 0 selects max (1) or min (0). Mode bit 1 selects magnitude (1) or value (0) ordering. Mode bits 3:2 select the family: 00 = 2008 number, 01 = 2019 minimum/maximum, 10 = 2019 number, 11 = C-style.
- R3: For ordinary non-NaN operands that differ, value ordering returns the signed minimum or maximum.
- R4: Magnitude ordering compares the operands with their sign bits cleared. When the magnitudes are equal, it returns what value ordering would return.
- R5: Under both 2019 families, and under magnitude ordering outside the C-style family, -0 orders below +0. The 2008 family with value ordering returns operand A when both operands are zeros.
- R6: The 2019 minimum/maximum family returns a NaN whenever either operand is NaN. It returns operand A if A is NaN, and otherwise operand B.
- R7: The 2008 and 2019 number families return the other operand when exactly one operand is a quiet NaN. They return operand A when both operands are NaN.
- R8: The 2008 family returns a signalling-NaN operand, with A taking precedence over B. The 2019 number family treats a signalling NaN like a quiet NaN when choosing its result.
- R9: The C-style family returns operand B when either operand is NaN, or when the operands compare equal under IEEE rules (±0 compare equal).
- R10: Every NaN result has its quiet bit (bit 51) set. Apart from that bit, the result equals one of the two operands.
- R11: invalid_o is 1 exactly when either operand was a signalling NaN (exponent all ones, bit 51 clear, fraction nonzero). This holds in every mode.
- R12: When rec_i is 1, cond_o is one-hot and reflects the IEEE value comparison of A against B: bit 3 = less, bit 2 = greater, bit 1 = equal, bit 0 = unordered. When rec_i is 0, cond_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| mode_i | input | 4 | Min/max, value/magnitude, family select |
| rec_i | input | 1 | Request a comparison summary |
| res_o | output | 64 | Selected operand, NaN quieted |
| invalid_o | output | 1 | A signalling-NaN operand was seen |
| cond_o | output | 4 | Comparison summary (zero unless requested) |

## Verification
The hardest cases are those where several rules overlap on one operand pair. Examples are two NaNs of different kinds under a number family, a signalling NaN under the C-style family, and a magnitude tie between opposite signs where the fallback order decides the result. The stimulus reaches these cases by sending specific NaN encodings directly: a quiet NaN with its sign set, and a signalling NaN with a nonzero low payload. The quieted payload then shows which operand was propagated. Signed-zero pairs are sent in both operand orders, so that the A-preference of the 2008 family and the B-preference of the C-style family can each be told apart from plain ordering.

// File: rtl/fp_mm_pkg.sv
package fp_mm_pkg;
  typedef enum logic [1:0] {
    FAM_NUM08 = 2'b00,
    FAM_MIN19 = 2'b01,
    FAM_NUM19 = 2'b10,
    FAM_CSTY  = 2'b11
  } mm_family_e;

  typedef struct packed {
    logic is_max;
    logic by_mag;
  } mm_sel_t;
endpackage

// File: rtl/fp_mm_classify.sv
module fp_mm_classify #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_i,
  output logic         nan_o,
  output logic         snan_o,
  output logic         zero_o,
  output logic         sign_o,
  output logic [W-2:0] mag_o
);
  logic exp_ones;
  logic man_nz;
  assign exp_ones = &op_i[W-2:MAN_W];
  assign man_nz   = |op_i[MAN_W-1:0];
  assign nan_o    = exp_ones & man_nz;
  assign snan_o   = nan_o & ~op_i[MAN_W-1];
  assign zero_o   = ~|op_i[W-2:0];
  assign sign_o   = op_i[W-1];
  assign mag_o    = op_i[W-2:0];
endmodule

// File: rtl/fp_mm_order.sv
module fp_mm_order #(
  parameter int MAG_W = 63
) (
  input  logic             sa_i,
  input  logic             sb_i,
  input  logic [MAG_W-1:0] ma_i,
  input  logic [MAG_W-1:0] mb_i,
  input  logic             za_i,
  input  logic             zb_i,
  output logic             tot_lt_o,
  output logic             mag_lt_o,
  output logic             mag_eq_o,
  output logic             ieee_eq_o,
  output logic             ieee_lt_o
);
  logic m_lt, m_gt;
  assign m_lt = ma_i < mb_i;
  assign m_gt = ma_i > mb_i;
  // total order on non-NaN values, -0 below +0
  assign tot_lt_o  = (sa_i & ~sb_i) | (~sa_i & ~sb_i & m_lt) | (sa_i & sb_i & m_gt);
  assign mag_lt_o  = m_lt;
  assign mag_eq_o  = ~m_lt & ~m_gt;
  assign ieee_eq_o = ((sa_i == sb_i) & mag_eq_o) | (za_i & zb_i);
  assign ieee_lt_o = tot_lt_o & ~ieee_eq_o;
endmodule

// File: rtl/fp_mm_select.sv
module fp_mm_select
  import fp_mm_pkg::*;
(
  input  mm_family_e fam_i,
  input  mm_sel_t    sel_i,
  input  logic       an_i,
  input  logic       bn_i,
  input  logic       as_i,
  input  logic       bs_i,
  input  logic       tot_lt_i,
  input  logic       mag_lt_i,
  input  logic       mag_eq_i,
  input  logic       ieee_eq_i,
  output logic       pick_a_o
);
  logic lt_ord, ord_pick;
  always_comb begin
    lt_ord   = sel_i.by_mag ? (mag_lt_i | (mag_eq_i & tot_lt_i)) : tot_lt_i;
    ord_pick = sel_i.is_max ? ~lt_ord : lt_ord;
    unique case (fam_i)
      FAM_CSTY:  pick_a_o = (an_i | bn_i | ieee_eq_i) ? 1'b0 : ord_pick;
      FAM_MIN19: pick_a_o = an_i ? 1'b1 : (bn_i ? 1'b0 : ord_pick);
      FAM_NUM08: begin
        if (as_i)                             pick_a_o = 1'b1;
        else if (bs_i)                        pick_a_o = 1'b0;
        else if (an_i)                        pick_a_o = bn_i;
        else if (bn_i)                        pick_a_o = 1'b1;
        else if (!sel_i.by_mag && ieee_eq_i)  pick_a_o = 1'b1;
        else                                  pick_a_o = ord_pick;
      end
      default: begin
        if (an_i)      pick_a_o = bn_i;
        else if (bn_i) pick_a_o = 1'b1;
        else           pick_a_o = ord_pick;
      end
    endcase
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fp_mm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   mode_i,
  input  logic         rec_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o,
  output logic [3:0]   cond_o
);
  localparam logic [W-1:0] QBIT = W'(1) << (MAN_W - 1);

  logic [1:0][W-1:0] ops;
  logic [1:0]        nan, snan, zero, sgn;
  logic [1:0][W-2:0] mag;
  assign ops = {b_i, a_i};

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fp_mm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
      .op_i(ops[g]), .nan_o(nan[g]), .snan_o(snan[g]), .zero_o(zero[g]),
      .sign_o(sgn[g]), .mag_o(mag[g])
    );
  end

  logic tot_lt, mag_lt, mag_eq, ieee_eq, ieee_lt, pick_a;
  fp_mm_order #(.MAG_W(W-1)) ord_i (
    .sa_i(sgn[0]), .sb_i(sgn[1]), .ma_i(mag[0]), .mb_i(mag[1]),
    .za_i(zero[0]), .zb_i(zero[1]), .tot_lt_o(tot_lt), .mag_lt_o(mag_lt),
    .mag_eq_o(mag_eq), .ieee_eq_o(ieee_eq), .ieee_lt_o(ieee_lt)
  );

  mm_sel_t sel;
  assign sel.is_max = mode_i[0];
  assign sel.by_mag = mode_i[1];

  fp_mm_select sel_i (
    .fam_i(mm_family_e'(mode_i[3:2])), .sel_i(sel), .an_i(nan[0]), .bn_i(nan[1]),
    .as_i(snan[0]), .bs_i(snan[1]), .tot_lt_i(tot_lt), .mag_lt_i(mag_lt),
    .mag_eq_i(mag_eq), .ieee_eq_i(ieee_eq), .pick_a_o(pick_a)
  );

  logic [W-1:0] res_d;
  logic [3:0]   cond_d;
  always_comb begin
    res_d = pick_a ? a_i : b_i;
    if (pick_a ? nan[0] : nan[1]) res_d = res_d | QBIT;
    if (!rec_i)            cond_d = 4'b0000;
    else if (|nan)         cond_d = 4'b0001;
    else if (ieee_eq)      cond_d = 4'b0010;
    else if (ieee_lt)      cond_d = 4'b1000;
    else                   cond_d = 4'b0100;
  end

  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      cond_o    <= '0;
      started_q <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= |snan;
      cond_o    <= cond_d;
      started_q <= 1'b1;
    end
  end

  p_nan_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&res_o[W-2:MAN_W] && |res_o[MAN_W-1:0]) |-> res_o[MAN_W-1]);

  p_res_from_operand_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (res_o == $past(a_i) || res_o == $past(b_i) ||
                   res_o == ($past(a_i) | QBIT) || res_o == ($past(b_i) | QBIT)));

  p_cond_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !$past(rec_i)) |-> (cond_o == 4'b0000));

  p_cond_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(rec_i)) |-> ($countones(cond_o) == 1));

  p_csty_nan_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(mode_i[3:2]) == 2'b11 && $past(|nan))
      |-> ((res_o | QBIT) == ($past(b_i) | QBIT)));
endmodule

// File: tb/fp_minmax_unit_tb.sv
module fp_minmax_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a, b;
  logic [3:0]  mode;
  logic        rec;
  logic [63:0] res;
  logic        inv;
  logic [3:0]  cond;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] THR  = 64'h4008000000000000;
  localparam logic [63:0] NTHR = 64'hC008000000000000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] QN   = 64'h7FF8000000000000;
  localparam logic [63:0] NQN  = 64'hFFF8000000000000;
  localparam logic [63:0] SN   = 64'h7FF0000000000001;
  localparam logic [63:0] SNQ  = 64'h7FF8000000000001;

  always #2.5 clk = ~clk;

  fp_minmax_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .mode_i(mode), .rec_i(rec),
    .res_o(res), .invalid_o(inv), .cond_o(cond)
  );

  task automatic chk(input string tag, input logic [63:0] ea, input logic [63:0] eb,
                     input logic [3:0] m, input logic r, input logic [63:0] er,
                     input logic ei, input logic [3:0] ec);
    @(negedge clk);
    a = ea; b = eb; mode = m; rec = r;
    @(negedge clk);
    total++;
    if (res !== er || inv !== ei || cond !== ec) begin
      bad++;
      $display("FAIL %s: res=%h inv=%b cond=%b expected res=%h inv=%b cond=%b",
               tag, res, inv, cond, er, ei, ec);
    end
  endtask

  task automatic t_reset;
    #1;
    total++;
    if (res !== 64'h0 || inv !== 1'b0 || cond !== 4'h0) begin
      bad++;
      $display("FAIL R1: res=%h inv=%b cond=%b expected 0 0 0", res, inv, cond);
    end
  endtask

  task automatic t_value;
    chk("R2 R3 min08", TWO, ONE, 4'b0000, 0, ONE, 0, 0);
    chk("R2 R3 max08", TWO, ONE, 4'b0001, 0, TWO, 0, 0);
    chk("R3 min19", NTHR, ONE, 4'b0100, 0, NTHR, 0, 0);
  endtask

  task automatic t_mag;
    chk("R4 minmag", NTHR, TWO, 4'b0010, 0, TWO, 0, 0);
    chk("R4 maxmag", NTHR, TWO, 4'b0011, 0, NTHR, 0, 0);
    chk("R4 minmag tie", THR, NTHR, 4'b0110, 0, NTHR, 0, 0);
    chk("R4 maxmag tie", NTHR, THR, 4'b1011, 0, THR, 0, 0);
  endtask

  task automatic t_zero;
    chk("R5 min19 zeros", PZ, NZ, 4'b0100, 0, NZ, 0, 0);
    chk("R5 max19 zeros", NZ, PZ, 4'b0101, 0, PZ, 0, 0);
    chk("R5 min08 zeros A", PZ, NZ, 4'b0000, 0, PZ, 0, 0);
    chk("R5 max08 zeros A", NZ, PZ, 4'b0001, 0, NZ, 0, 0);
    chk("R5 minmag08 zeros", PZ, NZ, 4'b0010, 0, NZ, 0, 0);
  endtask

  task automatic t_min19_nan;
    chk("R6 qnan A", QN, ONE, 4'b0100, 0, QN, 0, 0);
    chk("R6 R10 snan B", ONE, SN, 4'b0100, 0, SNQ, 1, 0);
    chk("R6 neg qnan B", TWO, NQN, 4'b0101, 0, NQN, 0, 0);
  endtask

  task automatic t_number;
    chk("R7 num19 qnan A", QN, TWO, 4'b1000, 0, TWO, 0, 0);
    chk("R7 num08 qnan B", ONE, QN, 4'b0001, 0, ONE, 0, 0);
    chk("R7 both nan", NQN, SN, 4'b1000, 0, NQN, 1, 0);
    chk("R8 num08 snan", ONE, SN, 4'b0000, 0, SNQ, 1, 0);
    chk("R8 num19 snan", SN, ONE, 4'b1000, 0, ONE, 1, 0);
  endtask

  task automatic t_cstyle;
    chk("R9 nan A", QN, ONE, 4'b1100, 0, ONE, 0, 0);
    chk("R9 nan B", ONE, QN, 4'b1100, 0, QN, 0, 0);
    chk("R9 zeros min", PZ, NZ, 4'b1100, 0, NZ, 0, 0);
    chk("R9 zeros max", NZ, PZ, 4'b1101, 0, PZ, 0, 0);
    chk("R9 ordinary", ONE, TWO, 4'b1100, 0, ONE, 0, 0);
    chk("R9 mag zeros", NZ, PZ, 4'b1110, 0, PZ, 0, 0);
    chk("R9 mag max", NTHR, TWO, 4'b1111, 0, NTHR, 0, 0);
    chk("R11 R10 snan csty", ONE, SN, 4'b1100, 0, SNQ, 1, 0);
  endtask

  task automatic t_cond;
    chk("R12 less", ONE, TWO, 4'b0000, 1, ONE, 0, 4'b1000);
    chk("R12 greater", TWO, ONE, 4'b0001, 1, TWO, 0, 4'b0100);
    chk("R12 equal zeros", PZ, NZ, 4'b0000, 1, PZ, 0, 4'b0010);
    chk("R12 unordered", QN, ONE, 4'b0100, 1, QN, 0, 4'b0001);
    chk("R12 off", ONE, TWO, 4'b0000, 0, ONE, 0, 4'b0000);
    chk("R11 no snan", THR, TWO, 4'b1101, 1, THR, 0, 4'b0100);
  endtask

  initial begin
    a = '0; b = '0; mode = '0; rec = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    t_reset();
    t_value();
    t_mag();
    t_zero();
    t_min19_nan();
    t_number();
    t_cstyle();
    t_cond();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule